// File: doc/BRIEF.md
# Car Park Gate Controller

This block runs the two gates of a car park that has one way in and one way out. The entrance and the exit are two separate local controllers that run at the same time. Neither of them knows the other's state. The only thing they share is a pool of free places, kept by a small zone counter that also tracks how many cars are inside.

At the entrance, an arriving car raises the arrival sensor. The controller then waits for the driver to take a ticket. Once a ticket has been taken and a place is free, it opens the gate and claims that place. When the sensor clears, the gate closes and the car is counted as inside. If the car park is full, a car that already has its ticket waits at a closed gate until a place is released. At the exit, a car raises the exit sensor and the controller waits for payment. It then opens the gate. When the sensor clears, the gate closes, one car is removed from the inside count and its place goes back to the pool.

All inputs are synchronous and already debounced. The sensors are levels, and the ticket and payment inputs are one-cycle pulses. The two gate commands are registered outputs.

Top module: `park_gate_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, both gates are closed, the free-place count equals CAPACITY and the inside count is zero.
- R2: In its idle state, the entrance takes a rising arrival sensor as the start of a visit. A ticket pulse sampled while it waits for a ticket, with at least one free place, opens the entrance gate on the following cycle and lowers the free count by one on that same cycle.
- R3: A ticket pulse sampled while no place is free leaves the entrance gate closed and the free count at zero. The entrance keeps the ticket and opens the gate, with no further ticket, on the cycle after the free count becomes nonzero.
- R4: A low arrival sensor sampled while the entrance gate is open closes that gate on the following cycle and raises the inside count by one.
- R5: In its idle state, the exit takes a rising exit sensor as the start of a visit. A pay pulse sampled while it waits for payment opens the exit gate on the following cycle.
- R6: A low exit sensor sampled while the exit gate is open closes that gate on the following cycle, lowers the inside count by one and raises the free count by one. If the inside count is already zero, both counts stay unchanged.
- R7: A ticket pulse sampled when the entrance is not waiting for a ticket, and a pay pulse sampled when the exit is not waiting for payment, are dropped and not remembered. A later visit still needs its own pulse before its gate opens.
- R8: If a place is claimed and a place is released in the same cycle, the free count does not change. If a car is counted in and a car is counted out in the same cycle, the inside count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| arrive_sense | input | 1 | Entrance car-present sensor level |
| ticket_taken | input | 1 | One-cycle pulse: a ticket was taken |
| depart_sense | input | 1 | Exit car-present sensor level |
| fee_paid | input | 1 | One-cycle pulse: payment is complete |
| entry_gate_open | output | 1 | Entrance gate command, registered |
| exit_gate_open | output | 1 | Exit gate command, registered |
| free_places | output | $clog2(CAPACITY+1) | Number of free places |
| cars_inside | output | $clog2(CAPACITY+1) | Number of cars counted inside |

## Verification
The bench builds the block with CAPACITY set to 3. With that value, a few cars fill the car park and a few more empty it, so both ends of both counters come within reach: the full state, with a ticketed car held at the entrance, and the empty state, where an exit must not drive the inside count below zero. In that small space the bench sweeps the car park from empty to full and back. It also times ticket and pay pulses against both controllers' waiting states. Last, it lines up entrance and exit events in the same cycle, so that a claim and a release, or a count-in and a count-out, land on the same edge.

// File: rtl/park_pkg.sv
package park_pkg;
  typedef enum logic [1:0] {
    ENT_IDLE  = 2'd0,
    ENT_TKT   = 2'd1,
    ENT_SPACE = 2'd2,
    ENT_OPEN  = 2'd3
  } ent_state_e;

  typedef enum logic [1:0] {
    EXT_IDLE = 2'd0,
    EXT_PAY  = 2'd1,
    EXT_OPEN = 2'd2
  } ext_state_e;
endpackage

// File: rtl/park_edge.sv
module park_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/park_entry.sv
module park_entry
  import park_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic fall_i,
  input  logic ticket_i,
  input  logic space_i,
  output logic take_o,
  output logic enter_o,
  output logic gate_o
);
  ent_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    take_o  = 1'b0;
    enter_o = 1'b0;
    unique case (st_q)
      ENT_IDLE:  if (rise_i) st_d = ENT_TKT;
      ENT_TKT: begin
        if (ticket_i) begin
          if (space_i) begin
            st_d   = ENT_OPEN;
            take_o = 1'b1;
          end else begin
            st_d = ENT_SPACE;
          end
        end
      end
      ENT_SPACE: begin
        if (space_i) begin
          st_d   = ENT_OPEN;
          take_o = 1'b1;
        end
      end
      ENT_OPEN: begin
        if (fall_i) begin
          st_d    = ENT_IDLE;
          enter_o = 1'b1;
        end
      end
      default: st_d = ENT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ENT_IDLE;
      gate_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      gate_o <= (st_d == ENT_OPEN);
    end
  end

  // R2 / R3: the gate never opens without a place to give
  a_r3_open_needs_space: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o) |-> $past(space_i));

  // R4: the gate closes only after the sensor was seen low
  a_r4_close_after_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_o) |-> !$past(fall_i) == 1'b0);
endmodule

// File: rtl/park_exit.sv
module park_exit
  import park_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic fall_i,
  input  logic pay_i,
  output logic leave_o,
  output logic gate_o
);
  ext_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    leave_o = 1'b0;
    unique case (st_q)
      EXT_IDLE: if (rise_i) st_d = EXT_PAY;
      EXT_PAY:  if (pay_i)  st_d = EXT_OPEN;
      EXT_OPEN: begin
        if (fall_i) begin
          st_d    = EXT_IDLE;
          leave_o = 1'b1;
        end
      end
      default: st_d = EXT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= EXT_IDLE;
      gate_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      gate_o <= (st_d == EXT_OPEN);
    end
  end

  // R5 / R7: the exit gate opens only on a sampled pay pulse
  a_r5_open_on_pay: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o) |-> $past(pay_i));

  // R6: the exit gate closes only after its sensor fell
  a_r6_close_after_clear: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_o) |-> $past(fall_i));
endmodule

// File: rtl/park_zone.sv
module park_zone #(
  parameter int CAPACITY = 444,
  localparam int CW = $clog2(CAPACITY + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take_i,
  input  logic          enter_i,
  input  logic          leave_i,
  output logic [CW-1:0] free_o,
  output logic [CW-1:0] inside_o
);
  localparam logic [CW-1:0] CAP_V = CW'(CAPACITY);

  logic give;
  assign give = leave_i && (inside_o != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      free_o   <= CAP_V;
      inside_o <= '0;
    end else begin
      if (take_i && !give)      free_o <= free_o - 1'b1;
      else if (give && !take_i) free_o <= free_o + 1'b1;
      if (enter_i && !give)      inside_o <= inside_o + 1'b1;
      else if (give && !enter_i) inside_o <= inside_o - 1'b1;
    end
  end

  // R3: a place is never claimed from an empty pool
  a_r3_no_take_when_full: assert property (@(posedge clk) disable iff (rst)
    take_i |-> (free_o != '0));

  // R6: a lone release returns exactly one place
  a_r6_release_one: assert property (@(posedge clk) disable iff (rst)
    (leave_i && !take_i && inside_o != '0) |=> (free_o == $past(free_o) + CW'(1)));

  // R6: an exit with nobody inside leaves the inside count at zero
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (rst)
    (leave_i && !enter_i && inside_o == '0) |=> (inside_o == '0));

  // R8: a claim and a release on one edge cancel
  a_r8_claim_release_hold: assert property (@(posedge clk) disable iff (rst)
    (take_i && leave_i && inside_o != '0) |=> $stable(free_o));

  // R1: the pool never exceeds the capacity
  a_r1_pool_bound: assert property (@(posedge clk) disable iff (rst)
    (free_o <= CAP_V) && (inside_o <= CAP_V));
endmodule

// File: rtl/park_gate_ctrl.sv
module park_gate_ctrl #(
  parameter int CAPACITY = 444,
  localparam int CW = $clog2(CAPACITY + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arrive_sense,
  input  logic          ticket_taken,
  input  logic          depart_sense,
  input  logic          fee_paid,
  output logic          entry_gate_open,
  output logic          exit_gate_open,
  output logic [CW-1:0] free_places,
  output logic [CW-1:0] cars_inside
);
  logic arr_rise, arr_fall, dep_rise, dep_fall;
  logic take, enter, leave;

  park_edge u_arr_edge (
    .clk(clk), .rst(rst), .level_i(arrive_sense),
    .rise_o(arr_rise), .fall_o(arr_fall)
  );

  park_edge u_dep_edge (
    .clk(clk), .rst(rst), .level_i(depart_sense),
    .rise_o(dep_rise), .fall_o(dep_fall)
  );

  park_entry u_entry (
    .clk(clk), .rst(rst), .rise_i(arr_rise), .fall_i(arr_fall),
    .ticket_i(ticket_taken), .space_i(free_places != '0),
    .take_o(take), .enter_o(enter), .gate_o(entry_gate_open)
  );

  park_exit u_exit (
    .clk(clk), .rst(rst), .rise_i(dep_rise), .fall_i(dep_fall),
    .pay_i(fee_paid), .leave_o(leave), .gate_o(exit_gate_open)
  );

  park_zone #(.CAPACITY(CAPACITY)) u_zone (
    .clk(clk), .rst(rst), .take_i(take), .enter_i(enter), .leave_i(leave),
    .free_o(free_places), .inside_o(cars_inside)
  );

  // R1 / R6 / R8: places are conserved between pool, gate and lot
  a_r8_conservation: assert property (@(posedge clk) disable iff (rst)
    (32'(free_places) + 32'(cars_inside) + 32'(entry_gate_open)) <= CAPACITY);
endmodule

// File: tb/tb_park_gate_ctrl.sv
module tb_park_gate_ctrl;
  localparam int CAP = 3;
  localparam int CW  = $clog2(CAP + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic arrive_sense = 1'b0, ticket_taken = 1'b0;
  logic depart_sense = 1'b0, fee_paid = 1'b0;
  logic entry_gate_open, exit_gate_open;
  logic [CW-1:0] free_places, cars_inside;

  int checks = 0;
  int fails  = 0;
  int exp_free = CAP;
  int exp_in   = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  park_gate_ctrl #(.CAPACITY(CAP)) dut (
    .clk(clk), .rst(rst), .arrive_sense(arrive_sense), .ticket_taken(ticket_taken),
    .depart_sense(depart_sense), .fee_paid(fee_paid),
    .entry_gate_open(entry_gate_open), .exit_gate_open(exit_gate_open),
    .free_places(free_places), .cars_inside(cars_inside)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic counts(input string tag);
    chk({tag, " free"}, int'(free_places), exp_free);
    chk({tag, " inside"}, int'(cars_inside), exp_in);
  endtask

  task automatic enter_car();
    arrive_sense = 1'b1; step();
    chk("R2 gate shut before ticket", int'(entry_gate_open), 0);
    ticket_taken = 1'b1; step(); ticket_taken = 1'b0;
    exp_free--;
    chk("R2 gate open after ticket", int'(entry_gate_open), 1);
    counts("R2");
    arrive_sense = 1'b0; step();
    exp_in++;
    chk("R4 gate closed", int'(entry_gate_open), 0);
    counts("R4");
  endtask

  task automatic exit_car();
    depart_sense = 1'b1; step();
    chk("R5 gate shut before pay", int'(exit_gate_open), 0);
    fee_paid = 1'b1; step(); fee_paid = 1'b0;
    chk("R5 gate open after pay", int'(exit_gate_open), 1);
    depart_sense = 1'b0; step();
    if (exp_in > 0) begin exp_in--; exp_free++; end
    chk("R6 gate closed", int'(exit_gate_open), 0);
    counts("R6");
  endtask

  initial begin
    step(3);
    chk("R1 entry gate in reset", int'(entry_gate_open), 0);
    counts("R1 in reset");
    rst = 1'b0; step();
    chk("R1 entry gate", int'(entry_gate_open), 0);
    chk("R1 exit gate", int'(exit_gate_open), 0);
    counts("R1");

    // fill the lot from empty
    for (int k = 0; k < CAP; k++) enter_car();

    // full: a ticketed car waits (R3)
    arrive_sense = 1'b1; step();
    ticket_taken = 1'b1; step(); ticket_taken = 1'b0;
    chk("R3 gate shut when full", int'(entry_gate_open), 0);
    counts("R3 full");
    step(3);
    chk("R3 still held", int'(entry_gate_open), 0);
    exit_car();
    step();
    exp_free--;
    chk("R3 opens after release", int'(entry_gate_open), 1);
    counts("R3 claim");
    arrive_sense = 1'b0; step(); exp_in++;
    counts("R3 in");

    // stray ticket dropped (R7)
    exit_car();
    ticket_taken = 1'b1; step(); ticket_taken = 1'b0;
    chk("R7 stray ticket gate", int'(entry_gate_open), 0);
    counts("R7 stray ticket");
    arrive_sense = 1'b1; step();
    chk("R7 no ticket memory", int'(entry_gate_open), 0);
    step();
    chk("R7 still waiting", int'(entry_gate_open), 0);
    ticket_taken = 1'b1; step(); ticket_taken = 1'b0; exp_free--;
    chk("R7 opens on own ticket", int'(entry_gate_open), 1);
    arrive_sense = 1'b0; step(); exp_in++;
    counts("R7 ticket");

    // stray pay dropped (R7)
    fee_paid = 1'b1; step(); fee_paid = 1'b0;
    depart_sense = 1'b1; step();
    chk("R7 no pay memory", int'(exit_gate_open), 0);
    step();
    chk("R7 exit still waiting", int'(exit_gate_open), 0);
    fee_paid = 1'b1; step(); fee_paid = 1'b0;
    chk("R7 exit opens on own pay", int'(exit_gate_open), 1);
    depart_sense = 1'b0; step(); exp_in--; exp_free++;
    counts("R7 pay");

    // claim and release on one edge (R8)
    depart_sense = 1'b1; step();
    fee_paid = 1'b1; step(); fee_paid = 1'b0;
    arrive_sense = 1'b1; step();
    ticket_taken = 1'b1; depart_sense = 1'b0; step(); ticket_taken = 1'b0;
    exp_in--;
    chk("R8 entry opened", int'(entry_gate_open), 1);
    chk("R8 exit closed", int'(exit_gate_open), 0);
    counts("R8 claim+release");
    arrive_sense = 1'b0; step(); exp_in++;
    counts("R8 after");

    // count-in and count-out on one edge (R8)
    depart_sense = 1'b1; step();
    fee_paid = 1'b1; step(); fee_paid = 1'b0;
    arrive_sense = 1'b1; step();
    ticket_taken = 1'b1; step(); ticket_taken = 1'b0; exp_free--;
    counts("R8 both open");
    arrive_sense = 1'b0; depart_sense = 1'b0; step(); exp_free++;
    chk("R8 both closed", int'(entry_gate_open) + int'(exit_gate_open), 0);
    counts("R8 in+out");

    // empty the lot, then one extra exit (R6)
    while (exp_in > 0) exit_car();
    exit_car();
    counts("R6 empty extra exit");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule